// File: doc/BRIEF.md
# Boot PROM Access Sequencer

This block converts single processor requests aimed at the boot PROM area, or at the extended PROM area next to it, into timed cycles on an external memory bus. A static strap selects the memory width. When the strap selects a byte-wide part, a halfword or word read becomes a series of consecutive byte fetches. The block packs these fetches into a 32-bit result. When the strap selects the wide part, one access moves 32 data bits and 8 check bits. Every access starts with a quiet address-decode cycle. A programmable number of wait states then stretches each strobe. An active-low write-control input decides whether writes reach the part at all.

A small field register holds the PROM size code and the wait-state count. A one-cycle `cfg_wr` pulse loads it. The boot area has the only chip select. An address at or above the configured size is refused with an error response. The extended area never drives the chip select and has no size limit. Each of its beats, once the wait states have run out, waits for the external ready input.

The controller has four states. IDLE accepts a request (IDLE to DECODE). DECODE checks the request: a refused request goes to RESP, a permitted one goes to ACCESS. ACCESS counts wait states and beats: it stays in ACCESS for the next beat and goes to RESP after the last beat. RESP pulses the response for one cycle and returns to IDLE.

Top module: `boot_prom_seq`

## Requirements
- R1: In the cycle after a request is accepted (DECODE), `mem_cs`, `mem_oe` and `mem_we` are all low.
- R2: With `byte_mode_n` low, reads are packed big-endian. The byte at address offset k (the address's two low bits) lands in `resp_rdata` bits [31-8k:24-8k], and other lanes read zero. A word read fetches offsets 0,1,2,3 of its aligned word, a halfword read fetches offsets a,a+1 of its aligned pair, and a byte read fetches its own address. In this mode the memory byte is taken from `mem_rdata[7:0]`.
- R3: With `byte_mode_n` low and WS programmed wait states, a read of B beats (byte 1, halfword 2, word 4) takes B*(1+WS)+2 cycles. The count starts at the accepting clock edge and runs up to and including the `resp_done` cycle. A word read therefore takes 4*(1+WS)+2.
- R4: With `byte_mode_n` high, each access is one beat lasting 1+WS cycles. `resp_rdata` returns `mem_rdata[31:0]` and `resp_chk` returns `mem_rdata[39:32]`.
- R5: A write while `wr_en_n` is high ends after 2 cycles with `resp_err` set, and no strobe asserts. A write with `wr_en_n` low drives `mem_we` for 1+WS cycles and `mem_oe` never.
- R6: With `byte_mode_n` low, a halfword or word write is refused like R5. A byte write drives `req_wdata[7:0]` on `mem_wdata[7:0]` with the upper bits zero. In wide mode, `mem_wdata` carries all of `req_wdata`.
- R7: The size code n (0..7) sets a boot area of 128 KB << n. A boot access at or above that limit gets an error after 2 cycles and no chip select. An access inside the limit asserts `mem_cs` (active high) through every access cycle.
- R8: After reset, the size code is 0 (128 KB) and the wait-state count is all ones. A `cfg_wr` pulse loads both fields at the next edge.
- R9: Extended-area accesses (`req_ext` high) never assert `mem_cs` and have no size limit. A beat ends only once its wait states are spent and `ext_rdy` is sampled high. The strobe therefore lasts at least one cycle after the decode cycle, so the shortest access spends 2 cycles before the response.
- R10: `resp_done` is a single-cycle pulse. `req_ready` is low from the accepting edge until `resp_done` ends, and requests presented meanwhile are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load pulse for the size and wait-state fields |
| cfg_size_d | input | 3 | New size code |
| cfg_ws_d | input | 4 | New wait-state count |
| byte_mode_n | input | 1 | Strap, low selects byte-wide PROM |
| wr_en_n | input | 1 | Low permits PROM writes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_ext | input | 1 | 1 selects the extended area |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 24 | Byte address within the area |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | Response pulse |
| resp_err | output | 1 | Request refused, valid with resp_done |
| resp_rdata | output | 32 | Read data, valid with resp_done |
| resp_chk | output | 8 | Check bits from a wide read |
| mem_addr | output | 24 | Memory byte address |
| mem_cs | output | 1 | Boot PROM chip select, active high |
| mem_oe | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 40 | Data and check bits from memory |
| ext_rdy | input | 1 | Extended-area ready |

## Verification
The bench counts cycles from the edge that accepts a request until `resp_done` is seen. A permitted access gives beats*(1+WS)+2 cycles, a refused one gives 2, and an extended beat takes an extra cycle for each edge on which `ext_rdy` is still low. Every output is sampled on the falling edge. The bench adds up strobe cycles over the same window, so strobe lengths and quiet decode cycles are checked at the exact cycle they are due. In the falling edge after the accepting edge, the bench checks that all strobes are low. It raises `ext_rdy` at a chosen falling edge, so the expected count for a delayed ready is max(R, WS+2)+1. The memory model returns data computed from `mem_addr`, so packed results also confirm the fetch order.

// File: rtl/bprom_pkg.sv
package bprom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACCESS,
        ST_RESP
    } seq_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Index of the final beat for a request.
    function automatic logic [1:0] last_beat(input logic narrow, input logic wr,
                                             input logic [1:0] sz);
        logic [1:0] r;
        if (!narrow || wr) begin
            r = 2'd0;
        end else begin
            unique case (sz)
                SZ_BYTE: r = 2'd0;
                SZ_HALF: r = 2'd1;
                default: r = 2'd3;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/bprom_cfg.sv
module bprom_cfg #(
    parameter int SW   = 3,
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [SW-1:0]   size_d,
    input  logic [WS_W-1:0] ws_d,
    output logic [SW-1:0]   size_q,
    output logic [WS_W-1:0] ws_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
            ws_q   <= '1;
        end else if (cfg_wr) begin
            size_q <= size_d;
            ws_q   <= ws_d;
        end
    end

    p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (size_q == $past(size_d)) && (ws_q == $past(ws_d)));

endmodule

// File: rtl/bprom_check.sv
module bprom_check
    import bprom_pkg::*;
#(
    parameter int AW       = 24,
    parameter int SW       = 3,
    parameter int MIN_LOG2 = 17
) (
    input  logic [AW-1:0] addr,
    input  logic          ext,
    input  logic          wr,
    input  logic [1:0]    size,
    input  logic          narrow,
    input  logic          wr_ok,
    input  logic [SW-1:0] cfg_size,
    output logic          deny
);

    logic in_window;
    logic bad_write;

    always_comb begin
        in_window = ((addr >> (MIN_LOG2 + int'(cfg_size))) == '0);
        bad_write = wr && (!wr_ok || (narrow && (size != SZ_BYTE)));
        deny      = bad_write || (!ext && !in_window);
    end

endmodule

// File: rtl/bprom_pack.sv
module bprom_pack #(
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cap,
    input  logic             narrow,
    input  logic [1:0]       lane,
    input  logic [DW+CW-1:0] din,
    output logic [DW-1:0]    word_q,
    output logic [CW-1:0]    chk_q
);

    localparam int LANES = DW / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[8*g +: 8] <= '0;
            end else if (clear) begin
                word_q[8*g +: 8] <= '0;
            end else if (cap) begin
                if (!narrow) begin
                    word_q[8*g +: 8] <= din[8*g +: 8];
                end else if (int'(lane) == LANES - 1 - g) begin
                    word_q[8*g +: 8] <= din[7:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q <= '0;
        end else if (clear) begin
            chk_q <= '0;
        end else if (cap && !narrow) begin
            chk_q <= din[DW +: CW];
        end
    end

    p_lane_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clear && narrow && lane == 2'd0) |=> (word_q[DW-1 -: 8] == $past(din[7:0])));

    p_wide_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clear && !narrow) |=> (word_q == $past(din[DW-1:0])) && (chk_q == $past(din[DW +: CW])));

endmodule

// File: rtl/boot_prom_seq.sv
module boot_prom_seq
    import bprom_pkg::*;
#(
    parameter int AW       = 24,
    parameter int WS_W     = 4,
    parameter int MIN_LOG2 = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [2:0]      cfg_size_d,
    input  logic [WS_W-1:0] cfg_ws_d,
    input  logic            byte_mode_n,
    input  logic            wr_en_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_ext,
    input  logic            req_write,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_addr,
    input  logic [31:0]     req_wdata,
    output logic            resp_done,
    output logic            resp_err,
    output logic [31:0]     resp_rdata,
    output logic [7:0]      resp_chk,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs,
    output logic            mem_oe,
    output logic            mem_we,
    output logic [31:0]     mem_wdata,
    input  logic [39:0]     mem_rdata,
    input  logic            ext_rdy
);

    localparam int DW = 32;
    localparam int CW = 8;
    localparam int SW = 3;

    seq_state_t      state_q, state_d;
    logic [WS_W-1:0] wcnt_q, wcnt_d;
    logic [1:0]      bcnt_q, bcnt_d;
    logic [1:0]      last_q, last_d;
    logic [AW-1:0]   base_q, base_d;
    logic            ext_q, ext_d;
    logic            wr_q, wr_d;
    logic            nar_q, nar_d;
    logic            err_q, err_d;
    logic [1:0]      size_q, size_d;
    logic [DW-1:0]   wdata_q, wdata_d;

    logic [SW-1:0]   size_cfg;
    logic [WS_W-1:0] ws_cfg;
    logic            deny;
    logic            beat_end;
    logic            cap;
    logic            clear;
    logic [AW-1:0]   aligned;

    bprom_cfg #(.SW(SW), .WS_W(WS_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .size_d (cfg_size_d),
        .ws_d   (cfg_ws_d),
        .size_q (size_cfg),
        .ws_q   (ws_cfg)
    );

    bprom_check #(.AW(AW), .SW(SW), .MIN_LOG2(MIN_LOG2)) u_check (
        .addr     (base_q),
        .ext      (ext_q),
        .wr       (wr_q),
        .size     (size_q),
        .narrow   (nar_q),
        .wr_ok    (!wr_en_n),
        .cfg_size (size_cfg),
        .deny     (deny)
    );

    bprom_pack #(.DW(DW), .CW(CW)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .cap    (cap),
        .narrow (nar_q),
        .lane   (mem_addr[1:0]),
        .din    (mem_rdata),
        .word_q (resp_rdata),
        .chk_q  (resp_chk)
    );

    // Start address: in byte-wide mode reads begin at the aligned lane 0 of their unit.
    always_comb begin
        aligned = req_addr;
        if (!byte_mode_n) begin
            aligned[1] = (req_size == SZ_BYTE || req_size == SZ_HALF) ? req_addr[1] : 1'b0;
            aligned[0] = (req_size == SZ_BYTE) ? req_addr[0] : 1'b0;
        end
    end

    assign beat_end = (wcnt_q == '0) && (!ext_q || ext_rdy);
    assign cap      = (state_q == ST_ACCESS) && beat_end && !wr_q;
    assign clear    = (state_q == ST_IDLE) && req_valid;

    // Next-state process.
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        bcnt_d  = bcnt_q;
        last_d  = last_q;
        base_d  = base_q;
        ext_d   = ext_q;
        wr_d    = wr_q;
        nar_d   = nar_q;
        err_d   = err_q;
        size_d  = size_q;
        wdata_d = wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_DECODE;
                    base_d  = aligned;
                    ext_d   = req_ext;
                    wr_d    = req_write;
                    nar_d   = !byte_mode_n;
                    size_d  = req_size;
                    wdata_d = req_wdata;
                    err_d   = 1'b0;
                    bcnt_d  = '0;
                end
            end
            ST_DECODE: begin
                err_d   = deny;
                wcnt_d  = ws_cfg;
                bcnt_d  = '0;
                last_d  = last_beat(nar_q, wr_q, size_q);
                state_d = deny ? ST_RESP : ST_ACCESS;
            end
            ST_ACCESS: begin
                if (wcnt_q != '0) begin
                    wcnt_d = wcnt_q - 1'b1;
                end else if (beat_end) begin
                    if (bcnt_q == last_q) begin
                        state_d = ST_RESP;
                    end else begin
                        bcnt_d = bcnt_q + 2'd1;
                        wcnt_d = ws_cfg;
                    end
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            bcnt_q  <= '0;
            last_q  <= '0;
            base_q  <= '0;
            ext_q   <= 1'b0;
            wr_q    <= 1'b0;
            nar_q   <= 1'b0;
            err_q   <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            bcnt_q  <= bcnt_d;
            last_q  <= last_d;
            base_q  <= base_d;
            ext_q   <= ext_d;
            wr_q    <= wr_d;
            nar_q   <= nar_d;
            err_q   <= err_d;
            size_q  <= size_d;
            wdata_q <= wdata_d;
        end
    end

    // Output process.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        resp_done = (state_q == ST_RESP);
        resp_err  = (state_q == ST_RESP) && err_q;
        mem_cs    = (state_q == ST_ACCESS) && !ext_q;
        mem_oe    = (state_q == ST_ACCESS) && !wr_q;
        mem_we    = (state_q == ST_ACCESS) && wr_q;
        mem_addr  = base_q | AW'(bcnt_q);
        mem_wdata = nar_q ? {24'h0, wdata_q[7:0]} : wdata_q;
    end

    p_decode_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready) |-> (!mem_cs && !mem_oe && !mem_we));

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_err) |-> $past(!mem_cs && !mem_oe && !mem_we));

    p_we_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(!wr_en_n));

    p_cs_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs) |-> $past((mem_addr >> (MIN_LOG2 + int'(size_cfg))) == '0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> (!resp_done && req_ready));

endmodule

// File: tb/test_boot_prom_seq.sv
`timescale 1ns/1ps
module test_boot_prom_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_size_d = '0;
    logic [3:0]  cfg_ws_d = '0;
    logic        bm = 1'b0;
    logic        wr_en_n = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_ext = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_done, resp_err;
    logic [31:0] resp_rdata;
    logic [7:0]  resp_chk;
    logic [23:0] mem_addr;
    logic        mem_cs, mem_oe, mem_we;
    logic [31:0] mem_wdata;
    logic [39:0] mem_rdata;
    logic        ext_rdy = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int got_cnt, n_cs, n_oe, n_we;
    logic        got_err;
    logic [31:0] got_rdata, we_data;
    logic [7:0]  got_chk;
    logic [23:0] we_addr;

    always #4 clk = ~clk;

    function automatic logic [7:0] pb(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    function automatic logic [31:0] pw(input logic [23:0] a);
        return {a[7:0] ^ 8'h96, a};
    endfunction
    function automatic logic [7:0] pc(input logic [23:0] a);
        return a[15:8] ^ 8'h3C;
    endfunction

    assign mem_rdata = {pc(mem_addr), bm ? {24'h0, pb(mem_addr)} : pw(mem_addr)};

    boot_prom_seq i_boot_prom_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size_d(cfg_size_d),
        .cfg_ws_d(cfg_ws_d), .byte_mode_n(~bm), .wr_en_n(wr_en_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ext(req_ext),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_done(resp_done), .resp_err(resp_err),
        .resp_rdata(resp_rdata), .resp_chk(resp_chk), .mem_addr(mem_addr),
        .mem_cs(mem_cs), .mem_oe(mem_oe), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ext_rdy(ext_rdy)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] sz, input logic [3:0] ws);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_size_d = sz; cfg_ws_d = ws;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue one request; rdy_at = 0 keeps ext_rdy high, else raises it at that falling edge.
    task automatic issue(input logic ext, input logic wr, input logic [1:0] sz,
                         input logic [23:0] a, input logic [31:0] wd, input int rdy_at);
        logic fin;
        n_cs = 0; n_oe = 0; n_we = 0; got_cnt = 0; fin = 1'b0;
        @(negedge clk);
        ext_rdy = (rdy_at == 0);
        req_valid = 1'b1; req_ext = ext; req_write = wr; req_size = sz;
        req_addr = a; req_wdata = wd;
        while (!fin && got_cnt < 300) begin
            @(posedge clk);
            got_cnt++;
            @(negedge clk);
            if (got_cnt == 1) begin
                req_valid = 1'b0;
                check("R10 ready low after accept", req_ready, 0);
                check("R1 decode cycle strobes", {mem_cs, mem_oe, mem_we}, 0);
            end
            n_cs += int'(mem_cs);
            n_oe += int'(mem_oe);
            n_we += int'(mem_we);
            if (mem_we) begin
                we_data = mem_wdata;
                we_addr = mem_addr;
            end
            if (rdy_at != 0 && got_cnt == rdy_at) ext_rdy = 1'b1;
            if (resp_done) begin
                fin = 1'b1;
                got_err = resp_err;
                got_rdata = resp_rdata;
                got_chk = resp_chk;
            end
        end
        @(negedge clk);
        check("R10 done single pulse", {resp_done, req_ready}, 2'b01);
        ext_rdy = 1'b1;
    endtask

    task automatic t_reset;
        check("R8 reset outputs", {req_ready, resp_done, mem_cs, mem_oe, mem_we}, 5'b10000);
        bm = 1'b0;
        issue(0, 0, 2'd2, 24'h01FFFC, 0, 0);
        check("R8 reset ws=15 cycles", got_cnt, 18);
        check("R8 in-window ok", got_err, 0);
        check("R7 cs cycles", n_cs, 16);
        check("R4 rdata", got_rdata, pw(24'h01FFFC));
        issue(0, 0, 2'd2, 24'h020000, 0, 0);
        check("R8 reset size 128K err", got_err, 1);
        check("R7 refused cycles", got_cnt, 2);
        check("R7 no cs on refusal", n_cs, 0);
    endtask

    task automatic t_cfg;
        set_cfg(3'd1, 4'd2);
        bm = 1'b0;
        issue(0, 0, 2'd2, 24'h020000, 0, 0);
        check("R8 loaded size", got_err, 0);
        check("R8 loaded ws cycles", got_cnt, 5);
    endtask

    task automatic t_byte_word;
        bm = 1'b1;
        issue(0, 0, 2'd2, 24'h000105, 0, 0);
        check("R2 packed word", got_rdata, {pb(24'h104), pb(24'h105), pb(24'h106), pb(24'h107)});
        check("R3 word cycles 4*(1+2)+2", got_cnt, 14);
        check("R3 oe cycles", n_oe, 12);
        check("R7 cs cycles", n_cs, 12);
    endtask

    task automatic t_byte_sub;
        bm = 1'b1;
        issue(0, 0, 2'd0, 24'h00012E, 0, 0);
        check("R2 byte lane 2", got_rdata, {16'h0, pb(24'h12E), 8'h0});
        check("R3 byte cycles", got_cnt, 5);
        issue(0, 0, 2'd1, 24'h000133, 0, 0);
        check("R2 half lanes", got_rdata, {16'h0, pb(24'h132), pb(24'h133)});
        check("R3 half cycles", got_cnt, 8);
    endtask

    task automatic t_wide;
        bm = 1'b0;
        issue(0, 0, 2'd2, 24'h0001A8, 0, 0);
        check("R4 wide data", got_rdata, pw(24'h0001A8));
        check("R4 wide check bits", got_chk, pc(24'h0001A8));
        check("R4 wide cycles ws2", got_cnt, 5);
        set_cfg(3'd1, 4'd0);
        issue(0, 0, 2'd0, 24'h000010, 0, 0);
        check("R4 wide cycles ws0", got_cnt, 3);
        check("R4 byte read full word", got_rdata, pw(24'h000010));
        set_cfg(3'd1, 4'd2);
    endtask

    task automatic t_write;
        bm = 1'b0; wr_en_n = 1'b1;
        issue(0, 1, 2'd2, 24'h000040, 32'hDEADBEEF, 0);
        check("R5 disabled write err", got_err, 1);
        check("R5 disabled write cycles", got_cnt, 2);
        check("R5 no strobe", n_we + n_cs + n_oe, 0);
        wr_en_n = 1'b0; bm = 1'b1;
        issue(0, 1, 2'd1, 24'h000040, 32'hDEADBEEF, 0);
        check("R6 half write refused", got_err, 1);
        check("R6 no we", n_we, 0);
        issue(0, 1, 2'd0, 24'h000077, 32'h123456AB, 0);
        check("R6 byte write ok", got_err, 0);
        check("R6 byte write data", we_data, 32'h000000AB);
        check("R6 byte write addr", we_addr, 24'h000077);
        check("R5 we cycles", n_we, 3);
        check("R5 no oe on write", n_oe, 0);
        bm = 1'b0;
        issue(0, 1, 2'd2, 24'h000040, 32'hDEADBEEF, 0);
        check("R6 wide write data", we_data, 32'hDEADBEEF);
        check("R5 wide write cycles", got_cnt, 5);
        wr_en_n = 1'b1;
    endtask

    task automatic t_size;
        bm = 1'b0;
        set_cfg(3'd7, 4'd0);
        issue(0, 0, 2'd2, 24'hFFFFFC, 0, 0);
        check("R7 16MB top ok", got_err, 0);
        check("R7 16MB cs", n_cs, 1);
        set_cfg(3'd6, 4'd0);
        issue(0, 0, 2'd2, 24'hC00000, 0, 0);
        check("R7 8MB limit err", got_err, 1);
        issue(0, 0, 2'd2, 24'h7FFFFC, 0, 0);
        check("R7 8MB below limit", got_err, 0);
    endtask

    task automatic t_ext;
        bm = 1'b0;
        set_cfg(3'd0, 4'd0);
        issue(1, 0, 2'd2, 24'h900000, 0, 0);
        check("R9 no size limit", got_err, 0);
        check("R9 min cycles", got_cnt, 3);
        check("R9 no cs", n_cs, 0);
        check("R9 oe cycles", n_oe, 1);
        check("R9 ext data", got_rdata, pw(24'h900000));
        issue(1, 0, 2'd2, 24'h000200, 0, 6);
        check("R9 delayed ready cycles", got_cnt, 7);
        check("R9 delayed oe", n_oe, 5);
        set_cfg(3'd0, 4'd3);
        issue(1, 0, 2'd2, 24'h000200, 0, 1);
        check("R9 waits before early ready", got_cnt, 6);
        set_cfg(3'd0, 4'd0);
        bm = 1'b1;
        issue(1, 0, 2'd2, 24'h000300, 0, 0);
        check("R9 byte ext cycles", got_cnt, 6);
        check("R9 byte ext no cs", n_cs, 0);
        check("R2 ext packed", got_rdata, {pb(24'h300), pb(24'h301), pb(24'h302), pb(24'h303)});
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_byte_word();
        t_byte_sub();
        t_wide();
        t_write();
        t_size();
        t_ext();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule